// File: doc/BRIEF.md
# Multiplexed Address/Data Register Interface

This block puts a small control register file behind a microcontroller-style bus. That bus has eight bidirectional lines, and they carry both the register address and the data. A host first places an address on the lines and lowers the address strobe, which captures it. The host then either places data on the lines and pulses the active-low write strobe, or pulls the active-low read strobe so the block drives the selected register back.

All bus inputs are treated as asynchronous. Each passes through a two-flop synchroniser on the system clock, and strobe edges are detected on the synchronised copies. The file spans addresses 0x00 to 0x14. Two of those slots are read-only status windows: 0x08 and 0x14 return the two status input bytes. Every other mapped slot is a writable control byte. All writable bytes are visible at once on a flat output vector for the logic they control.

Top module: `mxb_regif`

## Requirements
- R1: After reset every writable register is 0x00, the read-only slots of `regs_flat` are 0x00, and `ad_oe` is low.
- R2: The address is captured from `ad_in` on a falling edge of the synchronised `ale`. Changes on `ad_in` while `ale` stays low do not change the selected register.
- R3: A rising edge of the synchronised `wr_n` stores the synchronised `ad_in` into the writable register at the captured address. Register k appears on `regs_flat[8k+7:8k]` within three clock edges of the `wr_n` rise.
- R4: A write changes only the addressed byte. Every other byte of `regs_flat` holds its value.
- R5: Writes to 0x08 and 0x14 are ignored, including any write of bit 7 at 0x14. Reads of 0x08 return `stat_a_in` and reads of 0x14 return `stat_b_in`.
- R6: Writes to addresses 0x15 to 0xFF are ignored, and reads of those addresses return 0x00.
- R7: `ad_oe` is high only while the synchronised `rd_n` is low. While it is high, `ad_out` holds the contents of the register at the captured address.
- R8: Holding `wr_n` low, or holding `rd_n` low, writes nothing. A store happens only on the rising edge of `wr_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 8 | Receive side of the multiplexed address/data lines |
| ad_out | output | 8 | Read data driven onto the lines |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ale | input | 1 | Address strobe; its falling edge captures the address |
| wr_n | input | 1 | Active-low write strobe; its rising edge stores data |
| rd_n | input | 1 | Active-low read strobe |
| stat_a_in | input | 8 | Status byte returned at 0x08 |
| stat_b_in | input | 8 | Status byte returned at 0x14 |
| regs_flat | output | 168 | All 21 register slots, byte k at bits 8k+7:8k; read-only slots read 0 |

## Verification
The checks assume that the host holds `ad_in` stable across each strobe edge for longer than the synchroniser latency, so address and data reach the edge detectors aligned. They also assume that `rd_n` and `wr_n` are never low together and that `rd_n` rests high through reset. The bench drives every bus phase at the falling clock edge and holds each level for four clocks. Random operations come only from complete address-then-write or address-then-read sequences, so the stimulus stays inside these assumptions.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
    parameter int unsigned DW   = 8;
    parameter int unsigned NREG = 21;
    parameter int unsigned RO_A = 8;
    parameter int unsigned RO_B = 20;

    localparam int unsigned FLATW = NREG * DW;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic          ale_prev;
        logic          wr_prev;
    } dec_state_t;
endpackage

// File: rtl/mxb_sync.sv
module mxb_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/mxb_decode.sv
module mxb_decode
    import mxb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ad_s,
    input  logic          ale_s,
    input  logic          wr_n_s,
    output logic [DW-1:0] addr_o,
    output logic          wr_stb_o
);
    dec_state_t st_d, st_q;
    logic ale_fall;

    always_comb begin
        st_d          = st_q;
        ale_fall      = st_q.ale_prev && !ale_s;
        wr_stb_o      = !st_q.wr_prev && wr_n_s;
        st_d.ale_prev = ale_s;
        st_d.wr_prev  = wr_n_s;
        if (ale_fall) st_d.addr = ad_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{addr: '0, ale_prev: 1'b0, wr_prev: 1'b1};
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
endmodule

// File: rtl/mxb_regfile.sv
module mxb_regfile
    import mxb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    addr,
    input  logic             wr_stb,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-1:0]    stat_a,
    input  logic [DW-1:0]    stat_b,
    output logic [FLATW-1:0] regs_flat,
    output logic [DW-1:0]    rd_data
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] r;
    } file_t;

    file_t f_d, f_q;

    function automatic logic writable(int unsigned idx);
        return (idx < NREG) && (idx != RO_A) && (idx != RO_B);
    endfunction

    always_comb begin
        f_d = f_q;
        for (int unsigned i = 0; i < NREG; i++) begin
            if (wr_stb && (32'(addr) == i) && writable(i)) f_d.r[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g == RO_A || g == RO_B) begin : g_ro
            assign regs_flat[g*DW +: DW] = '0;
        end else begin : g_rw
            assign regs_flat[g*DW +: DW] = f_q.r[g];
        end
    end

    always_comb begin
        if (32'(addr) == RO_A)      rd_data = stat_a;
        else if (32'(addr) == RO_B) rd_data = stat_b;
        else if (32'(addr) < NREG)  rd_data = f_q.r[addr[$clog2(NREG)-1:0]];
        else                        rd_data = '0;
    end
endmodule

// File: rtl/mxb_regif.sv
module mxb_regif
    import mxb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    ad_in,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic             ale,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [DW-1:0]    stat_a_in,
    input  logic [DW-1:0]    stat_b_in,
    output logic [FLATW-1:0] regs_flat
);
    logic [DW-1:0] ad_s;
    logic [2:0]    ctl_s;
    logic [DW-1:0] addr_q;
    logic          wr_stb;
    logic [DW-1:0] rd_data;

    mxb_sync #(.W(DW), .RST_VAL('0)) i_sync_ad (
        .clk(clk), .rst_n(rst_n), .d(ad_in), .q(ad_s)
    );

    mxb_sync #(.W(3), .RST_VAL(3'b011)) i_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d({ale, wr_n, rd_n}), .q(ctl_s)
    );

    mxb_decode i_decode (
        .clk(clk), .rst_n(rst_n), .ad_s(ad_s),
        .ale_s(ctl_s[2]), .wr_n_s(ctl_s[1]),
        .addr_o(addr_q), .wr_stb_o(wr_stb)
    );

    mxb_regfile i_regfile (
        .clk(clk), .rst_n(rst_n), .addr(addr_q), .wr_stb(wr_stb),
        .wr_data(ad_s), .stat_a(stat_a_in), .stat_b(stat_b_in),
        .regs_flat(regs_flat), .rd_data(rd_data)
    );

    assign ad_oe  = !ctl_s[0];
    assign ad_out = rd_data;
endmodule

// File: rtl/mxb_regif_chk.sv
module mxb_regif_chk
    import mxb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rd_n,
    input logic             ad_oe,
    input logic [DW-1:0]    ad_out,
    input logic [DW-1:0]    addr_q,
    input logic             wr_stb,
    input logic [DW-1:0]    stat_a_in,
    input logic [DW-1:0]    stat_b_in,
    input logic [FLATW-1:0] regs_flat
);
    logic [FLATW-1:0] prev_q;
    logic [NREG-1:0]  changed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= regs_flat;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign changed[g] = regs_flat[g*DW +: DW] != prev_q[g*DW +: DW];
    end

    // R7
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && $past(rd_n) && $past(rd_n, 2)) |-> !ad_oe);

    // R4
    single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(changed));

    // R8
    strobe_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|changed) |-> $past(wr_stb));

    // R5
    ro_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && 32'(addr_q) == RO_A) |-> ad_out == stat_a_in);

    // R5
    ro_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && 32'(addr_q) == RO_B) |-> ad_out == stat_b_in);

    // R6
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && 32'(addr_q) >= NREG) |-> ad_out == '0);
endmodule

bind mxb_regif mxb_regif_chk i_chk (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .ad_oe(ad_oe), .ad_out(ad_out),
    .addr_q(addr_q), .wr_stb(wr_stb), .stat_a_in(stat_a_in),
    .stat_b_in(stat_b_in), .regs_flat(regs_flat)
);

// File: tb/test_mxb_regif.sv
`timescale 1ns/1ps
module test_mxb_regif;
    import mxb_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DW-1:0]    ad_in = '0;
    logic [DW-1:0]    ad_out;
    logic             ad_oe;
    logic             ale = 1'b0;
    logic             wr_n = 1'b1;
    logic             rd_n = 1'b1;
    logic [DW-1:0]    stat_a_in = 8'h3E;
    logic [DW-1:0]    stat_b_in = 8'hC1;
    logic [FLATW-1:0] regs_flat;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [DW-1:0] model [NREG];

    always #2.5 clk = ~clk;

    mxb_regif i_mxb_regif (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .ale(ale), .wr_n(wr_n), .rd_n(rd_n), .stat_a_in(stat_a_in),
        .stat_b_in(stat_b_in), .regs_flat(regs_flat)
    );

    function automatic bit can_write(int unsigned a);
        return a < NREG && a != RO_A && a != RO_B;
    endfunction

    function automatic logic [DW-1:0] exp_read(int unsigned a);
        if (a == RO_A) return stat_a_in;
        if (a == RO_B) return stat_b_in;
        if (a < NREG)  return model[a];
        return '0;
    endfunction

    function automatic logic [FLATW-1:0] exp_flat();
        logic [FLATW-1:0] v = '0;
        for (int i = 0; i < NREG; i++)
            if (can_write(i)) v[i*DW +: DW] = model[i];
        return v;
    endfunction

    task automatic chk(string req, logic [FLATW-1:0] act, logic [FLATW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_addr(logic [DW-1:0] a);
        ad_in = a; ale = 1'b1; hold(4);
        ale = 1'b0; hold(4);
    endtask

    task automatic do_write(logic [DW-1:0] a, logic [DW-1:0] d);
        send_addr(a);
        ad_in = d; wr_n = 1'b0; hold(4);
        wr_n = 1'b1; hold(4);
        if (can_write(a)) model[a] = d;
    endtask

    task automatic do_read(logic [DW-1:0] a, output logic [DW-1:0] d, output logic oe);
        send_addr(a);
        ad_in = 8'h5A; rd_n = 1'b0; hold(4);
        d = ad_out; oe = ad_oe;
        rd_n = 1'b1; hold(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic oe;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NREG; i++) model[i] = '0;
        hold(3);
        rst_n = 1'b1;
        hold(2);

        // R1 reset state
        chk("R1", regs_flat, '0);
        chk("R1", {167'b0, ad_oe}, '0);

        // R3 first and last writable registers
        do_write(8'h00, 8'hA5);
        chk("R3", {160'b0, regs_flat[7:0]}, {160'b0, 8'hA5});
        do_write(8'h13, 8'h3C);
        chk("R3", {160'b0, regs_flat[19*8 +: 8]}, {160'b0, 8'h3C});
        chk("R4", regs_flat, exp_flat());

        // R5 read-only slots ignore writes and return status
        do_write(8'h08, 8'hFF);
        do_write(8'h14, 8'h80);
        chk("R5", regs_flat, exp_flat());
        do_read(8'h08, rd, oe);
        chk("R5", {160'b0, rd}, {160'b0, stat_a_in});
        do_read(8'h14, rd, oe);
        chk("R5", {160'b0, rd}, {160'b0, stat_b_in});

        // R6 unmapped addresses
        do_write(8'h15, 8'h77);
        do_write(8'hFF, 8'h11);
        chk("R6", regs_flat, exp_flat());
        do_read(8'h15, rd, oe);
        chk("R6", {160'b0, rd}, '0);
        do_read(8'hFF, rd, oe);
        chk("R6", {160'b0, rd}, '0);

        // R7 output enable follows rd_n
        chk("R7", {167'b0, ad_oe}, '0);
        do_read(8'h00, rd, oe);
        chk("R7", {167'b0, oe}, 1);
        chk("R7", {160'b0, rd}, {160'b0, 8'hA5});
        chk("R7", {167'b0, ad_oe}, '0);

        // R2 address stays latched while ale stays low
        send_addr(8'h00);
        ad_in = 8'h13; hold(4);
        rd_n = 1'b0; hold(4);
        chk("R2", {160'b0, ad_out}, {160'b0, 8'hA5});
        rd_n = 1'b1; hold(4);

        // R8 no store while wr_n held low; store on its rise
        send_addr(8'h05);
        ad_in = 8'h69; wr_n = 1'b0; hold(6);
        chk("R8", regs_flat, exp_flat());
        wr_n = 1'b1; hold(4);
        model[5] = 8'h69;
        chk("R8", regs_flat, exp_flat());
        rd_n = 1'b0; hold(6);
        chk("R8", regs_flat, exp_flat());
        rd_n = 1'b1; hold(4);

        // random mix
        for (int k = 0; k < 200; k++) begin
            logic [DW-1:0] a, d;
            a = ($urandom % 8 == 0) ? DW'($urandom) : DW'($urandom % 32);
            d = DW'($urandom);
            if ($urandom % 10 == 0) begin
                stat_a_in = DW'($urandom);
                stat_b_in = DW'($urandom);
            end
            if ($urandom % 2 == 0) begin
                do_write(a, d);
                chk("R3/R4", regs_flat, exp_flat());
            end else begin
                do_read(a, rd, oe);
                chk("R7", {160'b0, rd}, {160'b0, exp_read(a)});
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule